// File: doc/BRIEF.md
# Serial Error Status Readout Unit

This unit keeps a 16-bit status word built from raw condition lines and lets a host read it over a read-only serial link. The link uses an active-low chip select and a serial clock, and the host never writes to the unit. The unit also drives an active-low error indication pin, so the host can see a fault without polling.

The unit has two indication modes.

- **Latched mode:** the status bits hold every condition seen. A complete, well-formed readout frame clears the bits whose conditions are gone.
- **Simple mode:** the error pin follows the live conditions and the serial output stays released.

The mode select input is sampled only while the I/O supply is healthy. The error pin is active only in the normal operating state.

The serial inputs are sampled on the system clock, which must be several times faster than the serial clock. Edges of the chip select and the serial clock are found from the previous sample. The system reset is synchronous and active-high.

Top module: `errstat_spi`

## Requirements
- R1: After reset the unit is in latched mode, `sdo_oe` is 0, `err_ind_n` is 1 and a readout returns all zeros.
- R2: While `cs_n` is high, `sdo_oe` is 0. Serial clock edges seen while `cs_n` is high do not shift data or count toward a frame.
- R3: When `cs_n` falls in latched mode, `sdo_oe` becomes 1 and `sdo` drives 0 until the first rising serial clock edge.
- R4: The status word is captured when `cs_n` falls. Each rising serial clock edge then puts the next bit on `sdo`, most significant first, so rising edge k (1..16) presents status bit 16-k. A bit reads as 1 when its condition line `cond[i]` was seen active.
- R5: In latched mode, a one-cycle pulse on `cond[i]` sets status bit i. The bit stays set until a completed frame clears it.
- R6: A frame completes when exactly 16 rising serial clock edges fall between the fall and the rise of `cs_n`. At completion, each bit whose condition was inactive for the whole frame and at release is cleared. Bits whose condition was still active stay set.
- R7: A frame with fewer or more than 16 rising edges clears nothing. `sdo_oe` still returns to 0 when `cs_n` rises.
- R8: A condition that becomes active during a frame keeps its bit set after that frame completes, so the next readout reports it.
- R9: In latched mode, `err_ind_n` is 0 exactly when `normal_op` is 1 and any of status bits 5 through 10 is set. Bits 0-4 and 11-15 never affect it.
- R10: In simple mode (`mode_sel`=1), `err_ind_n` is 0 exactly when `normal_op` is 1 and any of `cond[10:5]` is active right now. Nothing is latched, and `sdo_oe` stays 0 even with `cs_n` low.
- R11: While `uv_io` is 1, the active mode does not change, whatever `mode_sel` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| mode_sel | input | 1 | Requested mode: 0 latched, 1 simple |
| uv_io | input | 1 | I/O supply undervoltage flag; freezes the mode |
| normal_op | input | 1 | Normal operating state; enables the error pin |
| cond | input | 16 | Raw condition lines, bit i feeds status bit i |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| err_ind_n | output | 1 | Active-low error indication |

## Verification
Two functions can fall in the same cycle: the clearing of a completed frame and the setting of a bit by a new condition. The bench provokes this by pulsing a condition line in the middle of a frame that then completes. It judges the result by a second readout, which must still report that bit while every other bit has been cleared. Random condition masks between readouts, together with the error pin checks after each pulse, also show that setting and clearing never hide each other.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int STAT_W = 16;
    localparam int ERR_LO = 5;
    localparam int ERR_HI = 10;

    typedef enum logic {
        IND_LATCHED = 1'b0,
        IND_SIMPLE  = 1'b1
    } ind_mode_e;

    function automatic logic any_err(input logic [STAT_W-1:0] v);
        return |v[ERR_HI:ERR_LO];
    endfunction

endpackage

// File: rtl/errstat_shift.sv
module errstat_shift #(
    parameter int W = errstat_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic [W-1:0] stat_in,
    output logic         frame_start,
    output logic         frame_open,
    output logic         frame_done,
    output logic         sdo,
    output logic         sdo_oe
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(W + 1);

    logic         cs_prev_q, sclk_prev_q, open_q, sdo_q;
    logic [W-1:0] shreg_q;
    logic [CW-1:0] cnt_q;
    logic         sclk_up;

    assign frame_start = en && cs_prev_q && !cs_n;
    assign sclk_up     = open_q && !cs_n && !sclk_prev_q && sclk;
    assign frame_done  = en && open_q && cs_n && (cnt_q == CNT_FULL);
    assign frame_open  = open_q;
    assign sdo         = sdo_q;
    assign sdo_oe      = open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
            open_q      <= 1'b0;
            sdo_q       <= 1'b0;
            shreg_q     <= '0;
            cnt_q       <= '0;
        end else begin
            cs_prev_q   <= cs_n;
            sclk_prev_q <= sclk;
            if (!en) begin
                open_q <= 1'b0;
            end else if (frame_start) begin
                open_q  <= 1'b1;
                shreg_q <= stat_in;
                cnt_q   <= '0;
                sdo_q   <= 1'b0;
            end else if (open_q && cs_n) begin
                open_q <= 1'b0;
            end else if (sclk_up) begin
                sdo_q   <= shreg_q[W-1];
                shreg_q <= {shreg_q[W-2:0], 1'b0};
                if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a released select for two samples leaves the output released
    a_r2_idle_hiz: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !sdo_oe);
    // R7: the edge counter saturates and never wraps
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_SAT);
    // R3: right after a select fall the line is driven low
    a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (sdo_oe && !sdo));

endmodule

// File: rtl/errstat_flags.sv
module errstat_flags #(
    parameter int W = errstat_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         simple,
    input  logic [W-1:0] cond,
    input  logic         frame_start,
    input  logic         frame_open,
    input  logic         frame_done,
    output logic [W-1:0] status
);
    logic [W-1:0] status_q, seen_q, clr_mask;

    assign clr_mask = ~cond & ~seen_q;
    assign status   = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            seen_q   <= '0;
        end else begin
            if (frame_start)     seen_q <= cond;
            else if (frame_open) seen_q <= seen_q | cond;

            if (simple)          status_q <= cond;
            else if (frame_done) status_q <= (status_q & ~clr_mask) | cond;
            else                 status_q <= status_q | cond;
        end
    end

    // R5: an active condition is reflected in the status on the next cycle
    a_r5_set: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((status_q & $past(cond)) == $past(cond)));
    // R6 R7: a bit only drops on a completed frame or in simple mode
    a_r6_clear_only_done: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && |($past(status_q) & ~status_q)) |->
            ($past(frame_done) || $past(simple)));

endmodule

// File: rtl/errstat_ind.sv
module errstat_ind #(
    parameter int W = errstat_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_sel,
    input  logic         uv_io,
    input  logic         normal_op,
    input  logic [W-1:0] cond,
    input  logic [W-1:0] status,
    output logic         simple,
    output logic         err_ind_n
);
    import errstat_pkg::*;

    ind_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= IND_LATCHED;
        else if (!uv_io) mode_q <= ind_mode_e'(mode_sel);
    end

    assign simple    = (mode_q == IND_SIMPLE);
    assign err_ind_n = !(normal_op && any_err(simple ? cond : status));

    // R11: undervoltage freezes the mode
    a_r11_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(uv_io) |-> $stable(mode_q));

endmodule

// File: rtl/errstat_spi.sv
module errstat_spi #(
    parameter int W = errstat_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         mode_sel,
    input  logic         uv_io,
    input  logic         normal_op,
    input  logic [W-1:0] cond,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         err_ind_n
);
    logic         simple, f_start, f_open, f_done;
    logic [W-1:0] status;

    errstat_ind #(.W(W)) u_ind (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .uv_io(uv_io),
        .normal_op(normal_op), .cond(cond), .status(status),
        .simple(simple), .err_ind_n(err_ind_n)
    );

    errstat_shift #(.W(W)) u_shift (
        .clk(clk), .rst(rst), .en(!simple), .cs_n(cs_n), .sclk(sclk),
        .stat_in(status), .frame_start(f_start), .frame_open(f_open),
        .frame_done(f_done), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    errstat_flags #(.W(W)) u_flags (
        .clk(clk), .rst(rst), .simple(simple), .cond(cond),
        .frame_start(f_start), .frame_open(f_open), .frame_done(f_done),
        .status(status)
    );

    // R10: simple mode never enables the serial output
    a_r10_simple_hiz: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(simple) && simple |-> !sdo_oe);

endmodule

// File: tb/errstat_spi_bench.sv
module errstat_spi_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, cs_n, sclk, mode_sel, uv_io, normal_op;
    logic [15:0] cond;
    logic        sdo, sdo_oe, err_ind_n;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errstat_spi u_errstat_spi (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mode_sel(mode_sel),
        .uv_io(uv_io), .normal_op(normal_op), .cond(cond),
        .sdo(sdo), .sdo_oe(sdo_oe), .err_ind_n(err_ind_n)
    );

    function automatic logic exp_errn(input logic nop, input logic [15:0] v);
        return !(nop && (|v[10:5]));
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs one frame of nclk rising edges; mid_bit >= 0 pulses that condition mid-frame
    task automatic do_read(input int nclk, input int mid_bit, output logic [15:0] data);
        data = '0;
        cs_n = 1'b0;
        tick(2);
        check("R3 start oe/low", {14'd0, sdo_oe, sdo}, 16'h0002);
        for (int k = 0; k < nclk; k++) begin
            sclk = 1'b1;
            tick(2);
            if (k < 16) data[15-k] = sdo;
            if (k == 8 && mid_bit >= 0) begin
                cond[mid_bit] = 1'b1;
                tick(1);
                cond[mid_bit] = 1'b0;
            end
            sclk = 1'b0;
            tick(2);
        end
        cs_n = 1'b1;
        tick(2);
        check("R2 released oe", {15'd0, sdo_oe}, 16'h0000);
    endtask

    task automatic pulse(input logic [15:0] m);
        cond = m;
        tick(1);
        cond = '0;
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, acc;
        void'($urandom(32'd20240611));
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mode_sel = 1'b0;
        uv_io = 1'b0; normal_op = 1'b1; cond = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 oe", {15'd0, sdo_oe}, 16'h0000);
        check("R1 errn", {15'd0, err_ind_n}, 16'h0001);
        do_read(16, -1, rd);
        check("R1 empty read", rd, 16'h0000);

        // R4 R5 directed pattern and MSB-first order
        pulse(16'hA5C3);
        check("R9 errn after pattern", {15'd0, err_ind_n}, {15'd0, exp_errn(1'b1, 16'hA5C3)});
        do_read(16, -1, rd);
        check("R4 msb-first pattern", rd, 16'hA5C3);
        do_read(16, -1, rd);
        check("R6 cleared after completed frame", rd, 16'h0000);
        check("R6 errn back high", {15'd0, err_ind_n}, 16'h0001);

        // R2 clock edges with select high are ignored
        pulse(16'h0300);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b1; tick(2);
            check("R2 oe while idle", {15'd0, sdo_oe}, 16'h0000);
            sclk = 1'b0; tick(2);
        end
        do_read(16, -1, rd);
        check("R2 frame unaffected by idle edges", rd, 16'h0300);

        // R6 persistent condition stays across a completed frame
        cond = 16'h0008;
        tick(2);
        do_read(16, -1, rd);
        check("R6 persistent read1", rd, 16'h0008);
        cond = '0;
        tick(1);
        do_read(16, -1, rd);
        check("R6 persistent read2", rd, 16'h0008);
        do_read(16, -1, rd);
        check("R6 persistent read3", rd, 16'h0000);

        // R7 short and long frames clear nothing
        pulse(16'h0080);
        do_read(15, -1, rd);
        do_read(17, -1, rd);
        check("R7 long frame data", rd, 16'h0080);
        check("R7 errn still low", {15'd0, err_ind_n}, 16'h0000);
        do_read(16, -1, rd);
        check("R7 survives aborted frames", rd, 16'h0080);
        do_read(16, -1, rd);
        check("R7 then cleared", rd, 16'h0000);

        // R8 event during a completing frame is kept
        pulse(16'h0001);
        do_read(16, 12, rd);
        check("R8 frame data", rd, 16'h0001);
        do_read(16, -1, rd);
        check("R8 mid-frame event kept", rd, 16'h1000);
        do_read(16, -1, rd);
        check("R8 cleared later", rd, 16'h0000);

        // R9 non-error bits and operating state gating
        pulse(16'h801F);
        check("R9 non-error bits", {15'd0, err_ind_n}, 16'h0001);
        pulse(16'h0200);
        normal_op = 1'b0; tick(1);
        check("R9 not normal", {15'd0, err_ind_n}, 16'h0001);
        normal_op = 1'b1; tick(1);
        check("R9 normal", {15'd0, err_ind_n}, 16'h0000);
        do_read(16, -1, rd);
        check("R9 read", rd, 16'h821F);

        // R5 R4 random masks between readouts
        acc = '0;
        for (int it = 0; it < 30; it++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if (($urandom % 3) == 0) m = m & 16'h8421;
            pulse(m);
            acc = acc | m;
            check("R5 errn after pulse", {15'd0, err_ind_n}, {15'd0, exp_errn(1'b1, acc)});
            if (($urandom % 2) == 0) begin
                do_read(16, -1, rd);
                check("R5 random read", rd, acc);
                acc = '0;
            end
        end
        do_read(16, -1, rd);
        check("R5 final random read", rd, acc);

        // R10 simple mode
        mode_sel = 1'b1; tick(2);
        cond = 16'h0040; tick(1);
        check("R10 live low", {15'd0, err_ind_n}, 16'h0000);
        cond = 16'h0004; tick(1);
        check("R10 non-error live", {15'd0, err_ind_n}, 16'h0001);
        cond = '0; tick(1);
        check("R10 no latch", {15'd0, err_ind_n}, 16'h0001);
        cs_n = 1'b0; tick(3);
        check("R10 oe stays low", {15'd0, sdo_oe}, 16'h0000);
        cs_n = 1'b1; tick(2);

        // R11 mode frozen under undervoltage
        uv_io = 1'b1; mode_sel = 1'b0; tick(3);
        pulse(16'h0020);
        check("R11 still simple", {15'd0, err_ind_n}, 16'h0001);
        uv_io = 1'b0; tick(2);
        pulse(16'h0020);
        check("R11 latched after release", {15'd0, err_ind_n}, 16'h0000);
        do_read(16, -1, rd);
        check("R11 read", rd, 16'h0020);
        check("R11 errn cleared", {15'd0, err_ind_n}, 16'h0001);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule